// File: doc/BRIEF.md
# Two-Write Three-Read Distributed-RAM Register File

This block is the integer register file of a 32-bit in-order processor. It has three read ports that work combinationally and two write ports that are clocked. The decode stage reads operands through the three read ports. The write-back stage commits results through the two write ports. Every port takes a 5-bit register address. Register zero has no storage: it always reads as zero, and writes to it are dropped.

The storage is built only from elements with one synchronous write and an asynchronous read. These are the elements that map onto distributed RAM in programmable logic. Two write ports come from giving each write port its own bank. Each bank is copied once per read port, which gives six 31-entry banks. A small last-writer table records which write port most recently wrote each register, and each read port uses it to pick between the two banks. Only the last-writer table is reset; the data banks are not. A register therefore holds no defined value until it is first written.

Top module: `regfile_2w3r`

## Requirements
- R1: Each read port is combinational. When a read address changes, the matching data appears on that port within the same clock cycle, with no clock edge in between.
- R2: A read of address 0 returns 32'h0000_0000 on every read port at all times, including during and after reset.
- R3: A write to address 0 on either write port, with its enable high, changes no register. Every address still reads back the same value afterwards.
- R4: A write commits only at the rising clock edge. A read of the same address in the same cycle returns the old value, and the new value is visible from the next cycle on.
- R5: Both write ports can write two different non-zero addresses in the same cycle, and both values are stored.
- R6: When both write ports write the same non-zero address in one cycle, the value from write port B is stored.
- R7: A write port whose enable is low changes nothing, whatever its address and data inputs are.
- R8: Reset (rst_ni low) clears only the last-writer table, so every bank selection points to write port A. The data banks are not cleared. After reset, each register reads the last value written to it through port A, even if port B wrote it later.
- R9: Under random traffic on all ports, every read port matches a 32-entry reference model on every cycle once all registers have been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset of the last-writer table |
| rd_addr_a_i | input | 5 | Read port A address |
| rd_data_a_o | output | 32 | Read port A data |
| rd_addr_b_i | input | 5 | Read port B address |
| rd_data_b_o | output | 32 | Read port B data |
| rd_addr_c_i | input | 5 | Read port C address |
| rd_data_c_o | output | 32 | Read port C data |
| wr_en_a_i | input | 1 | Write port A enable |
| wr_addr_a_i | input | 5 | Write port A address |
| wr_data_a_i | input | 32 | Write port A data |
| wr_en_b_i | input | 1 | Write port B enable (wins on an address clash) |
| wr_addr_b_i | input | 5 | Write port B address |
| wr_data_b_i | input | 32 | Write port B data |

## Verification
The write-visibility and hold properties assume that inputs are stable around each rising edge. They also assume that rst_ni does not toggle between a write and the read that observes it. The bench drives every input on the falling edge and changes reset only there. The data properties also assume that a register has been written before it is read. Reads of unwritten registers return undefined contents and carry no obligation. The bench therefore fills every register through port A before it starts random traffic, and it checks a read only against registers its model marks as written.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_ADDR_W = 5;
  localparam int unsigned RF_DATA_W = 32;
  localparam int unsigned RF_N_RD   = 3;
  localparam int unsigned RF_N_WR   = 2;
endpackage

// File: rtl/rf_lutram_bank.sv
// One write, one asynchronous read; entry 0 has no storage.
module rf_lutram_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DEPTH  = (1 << ADDR_W) - 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [1:DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rf_lvt.sv
// Last-writer table: 0 = port A, 1 = port B. Port B wins same-address clashes.
module rf_lvt #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned N_RD   = 3,
  parameter int unsigned DEPTH  = (1 << ADDR_W) - 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_a_i,
  input  logic [ADDR_W-1:0]          waddr_a_i,
  input  logic                       we_b_i,
  input  logic [ADDR_W-1:0]          waddr_b_i,
  input  logic [N_RD-1:0][ADDR_W-1:0] raddr_i,
  output logic [N_RD-1:0]            sel_b_o
);
  logic [DEPTH:1] tbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q <= '0;
    end else begin
      if (we_a_i) tbl_q[waddr_a_i] <= 1'b0;
      if (we_b_i) tbl_q[waddr_b_i] <= 1'b1;
    end
  end

  for (genvar rp = 0; rp < N_RD; rp++) begin : g_sel
    assign sel_b_o[rp] = (raddr_i[rp] == '0) ? 1'b0 : tbl_q[raddr_i[rp]];
  end
endmodule

// File: rtl/regfile_2w3r.sv
module regfile_2w3r
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W = RF_DATA_W,
  parameter int unsigned ADDR_W = RF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_a_i,
  output logic [DATA_W-1:0] rd_data_a_o,
  input  logic [ADDR_W-1:0] rd_addr_b_i,
  output logic [DATA_W-1:0] rd_data_b_o,
  input  logic [ADDR_W-1:0] rd_addr_c_i,
  output logic [DATA_W-1:0] rd_data_c_o,
  input  logic              wr_en_a_i,
  input  logic [ADDR_W-1:0] wr_addr_a_i,
  input  logic [DATA_W-1:0] wr_data_a_i,
  input  logic              wr_en_b_i,
  input  logic [ADDR_W-1:0] wr_addr_b_i,
  input  logic [DATA_W-1:0] wr_data_b_i
);
  localparam int unsigned N_RD  = RF_N_RD;
  localparam int unsigned N_WR  = RF_N_WR;
  localparam int unsigned DEPTH = (1 << ADDR_W) - 1;

  logic [N_RD-1:0][ADDR_W-1:0] raddr;
  logic [N_RD-1:0][DATA_W-1:0] rdata;
  logic [N_WR-1:0]             we;
  logic [N_WR-1:0][ADDR_W-1:0] waddr;
  logic [N_WR-1:0][DATA_W-1:0] wdata;
  logic [N_RD-1:0]             sel_b;

  assign raddr = {rd_addr_c_i, rd_addr_b_i, rd_addr_a_i};
  assign waddr = {wr_addr_b_i, wr_addr_a_i};
  assign wdata = {wr_data_b_i, wr_data_a_i};
  // Writes to address 0 never reach storage or the table.
  assign we[0] = wr_en_a_i && (wr_addr_a_i != '0);
  assign we[1] = wr_en_b_i && (wr_addr_b_i != '0);

  rf_lvt #(.ADDR_W(ADDR_W), .N_RD(N_RD), .DEPTH(DEPTH)) i_lvt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_a_i   (we[0]),
    .waddr_a_i(waddr[0]),
    .we_b_i   (we[1]),
    .waddr_b_i(waddr[1]),
    .raddr_i  (raddr),
    .sel_b_o  (sel_b)
  );

  for (genvar rp = 0; rp < N_RD; rp++) begin : g_rd
    logic [N_WR-1:0][DATA_W-1:0] bank_q;
    for (genvar wp = 0; wp < N_WR; wp++) begin : g_wr
      rf_lutram_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_bank (
        .clk_i  (clk_i),
        .we_i   (we[wp]),
        .waddr_i(waddr[wp]),
        .wdata_i(wdata[wp]),
        .raddr_i(raddr[rp]),
        .rdata_o(bank_q[wp])
      );
    end
    always_comb begin
      if (raddr[rp] == '0) rdata[rp] = '0;
      else                 rdata[rp] = sel_b[rp] ? bank_q[1] : bank_q[0];
    end
  end

  assign rd_data_a_o = rdata[0];
  assign rd_data_b_o = rdata[1];
  assign rd_data_c_o = rdata[2];
endmodule

// File: rtl/rf_chk.sv
module rf_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] rd_addr_a_i,
  input logic [DATA_W-1:0] rd_data_a_o,
  input logic [ADDR_W-1:0] rd_addr_b_i,
  input logic [DATA_W-1:0] rd_data_b_o,
  input logic [ADDR_W-1:0] rd_addr_c_i,
  input logic [DATA_W-1:0] rd_data_c_o,
  input logic              wr_en_a_i,
  input logic [ADDR_W-1:0] wr_addr_a_i,
  input logic [DATA_W-1:0] wr_data_a_i,
  input logic              wr_en_b_i,
  input logic [ADDR_W-1:0] wr_addr_b_i,
  input logic [DATA_W-1:0] wr_data_b_i
);
  // R2
  zero_rd_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_a_i == '0) |-> (rd_data_a_o == '0));
  // R2
  zero_rd_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_b_i == '0) |-> (rd_data_b_o == '0));
  // R2
  zero_rd_c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_c_i == '0) |-> (rd_data_c_o == '0));
  // R6
  wr_b_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_b_i && wr_addr_b_i != '0) |=>
      ((rd_addr_a_i == $past(wr_addr_b_i)) |-> (rd_data_a_o == $past(wr_data_b_i))));
  // R5
  wr_a_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_a_i && wr_addr_a_i != '0 && !(wr_en_b_i && wr_addr_b_i == wr_addr_a_i)) |=>
      ((rd_addr_b_i == $past(wr_addr_a_i)) |-> (rd_data_b_o == $past(wr_data_a_i))));
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_a_i && !wr_en_b_i) |=>
      ($stable(rd_addr_c_i) |-> $stable(rd_data_c_o)));
endmodule

bind regfile_2w3r rf_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rf_chk (.*);

// File: tb/test_regfile_2w3r.sv
module test_regfile_2w3r;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int NREG = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] ra, rb, rc, wa_a, wa_b;
  logic [DW-1:0] da, db, dc, wd_a, wd_b;
  logic          we_a, we_b;

  logic [DW-1:0] ref_q    [NREG];
  logic          ref_v    [NREG];
  logic [DW-1:0] shadow_a [NREG];
  logic          shadow_v [NREG];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  regfile_2w3r i_regfile_2w3r (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_addr_a_i(ra), .rd_data_a_o(da),
    .rd_addr_b_i(rb), .rd_data_b_o(db),
    .rd_addr_c_i(rc), .rd_data_c_o(dc),
    .wr_en_a_i(we_a), .wr_addr_a_i(wa_a), .wr_data_a_i(wd_a),
    .wr_en_b_i(we_b), .wr_addr_b_i(wa_b), .wr_data_b_i(wd_b)
  );

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    return (a == '0) ? '0 : ref_q[a];
  endfunction

  function automatic bit known(input logic [AW-1:0] a);
    return (a == '0) || ref_v[a];
  endfunction

  task automatic chk(input string tag, input string port, input logic [AW-1:0] a,
                     input logic [DW-1:0] act);
    if (known(a)) begin
      checks++;
      if (act !== exp_rd(a)) begin
        errors++;
        $display("FAIL %s port %s addr %0d: actual %h expected %h", tag, port, a, act, exp_rd(a));
      end
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "a", ra, da);
    chk(tag, "b", rb, db);
    chk(tag, "c", rc, dc);
  endtask

  // Drive on falling edge, check before rising edge, then update model.
  task automatic step(input string tag,
                      input logic ea, input logic [AW-1:0] aa, input logic [DW-1:0] xa,
                      input logic eb, input logic [AW-1:0] ab, input logic [DW-1:0] xb,
                      input logic [AW-1:0] r0, input logic [AW-1:0] r1, input logic [AW-1:0] r2);
    @(negedge clk);
    we_a = ea; wa_a = aa; wd_a = xa;
    we_b = eb; wa_b = ab; wd_b = xb;
    ra = r0; rb = r1; rc = r2;
    #2;
    chk_all(tag);
    @(posedge clk);
    if (ea && aa != '0) begin
      ref_q[aa] = xa; ref_v[aa] = 1'b1;
      shadow_a[aa] = xa; shadow_v[aa] = 1'b1;
    end
    if (eb && ab != '0) begin
      ref_q[ab] = xb; ref_v[ab] = 1'b1;
    end
  endtask

  task automatic idle_read(input string tag, input logic [AW-1:0] r0,
                           input logic [AW-1:0] r1, input logic [AW-1:0] r2);
    step(tag, 1'b0, '0, '0, 1'b0, '0, '0, r0, r1, r2);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < NREG; i += 3)
      idle_read(tag, AW'(i), AW'((i + 1) % NREG), AW'((i + 2) % NREG));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < NREG; i++) begin
      ref_v[i] = 1'b0; shadow_v[i] = 1'b0; ref_q[i] = '0; shadow_a[i] = '0;
    end
    we_a = 0; we_b = 0; wa_a = '0; wa_b = '0; wd_a = '0; wd_b = '0;
    ra = '0; rb = '0; rc = '0;
    // R2: zero reads during reset
    #5;
    chk_all("R2");
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // Fill every register through port A
    for (int r = 1; r < NREG; r++)
      step("R9", 1'b1, AW'(r), 32'h1000_0000 + DW'(r) * 32'h0101, 1'b0, '0, '0, '0, '0, '0);
    sweep("R9");

    // R1: change read addresses within one cycle, no edge between
    @(negedge clk);
    we_a = 0; we_b = 0;
    ra = 5'd3; rb = 5'd7; rc = 5'd0;
    #1 chk_all("R1");
    ra = 5'd30; rb = 5'd1; rc = 5'd17;
    #1 chk_all("R1");

    // R3: write to address 0 on both ports
    step("R3", 1'b1, '0, 32'hFFFF_FFFF, 1'b1, '0, 32'hDEAD_BEEF, '0, '0, '0);
    sweep("R3");

    // R4: read-during-write returns old, new value next cycle
    step("R4", 1'b1, 5'd4, 32'hAAAA_0004, 1'b1, 5'd9, 32'hBBBB_0009, 5'd4, 5'd9, 5'd4);
    idle_read("R4", 5'd4, 5'd9, 5'd0);

    // R5: distinct addresses same cycle
    step("R5", 1'b1, 5'd12, 32'h1212_1212, 1'b1, 5'd21, 32'h2121_2121, '0, '0, '0);
    idle_read("R5", 5'd12, 5'd21, 5'd12);

    // R6: same address both ports, B wins
    step("R6", 1'b1, 5'd15, 32'hA5A5_A5A5, 1'b1, 5'd15, 32'h5A5A_5A5A, '0, '0, '0);
    idle_read("R6", 5'd15, 5'd15, 5'd15);

    // R7: enables low with live address/data
    step("R7", 1'b0, 5'd8, 32'hCAFE_0008, 1'b0, 5'd8, 32'hCAFE_1008, 5'd8, '0, '0);
    idle_read("R7", 5'd8, 5'd8, 5'd8);

    // R9: random traffic
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] aa, ab;
      aa = AW'($urandom);
      ab = ($urandom % 6 == 0) ? aa : AW'($urandom);
      step("R9", 1'($urandom), aa, $urandom, 1'($urandom), ab, $urandom,
           AW'($urandom), AW'($urandom), ($urandom % 4 == 0) ? aa : AW'($urandom));
    end

    // R8: reset returns selection to port A banks, storage kept
    step("R8", 1'b1, 5'd7, 32'h0A0A_0007, 1'b0, '0, '0, '0, '0, '0);
    step("R8", 1'b0, '0, '0, 1'b1, 5'd7, 32'h0B0B_0007, '0, '0, '0);
    idle_read("R8", 5'd7, '0, '0);
    @(negedge clk) rst_ni = 1'b0;
    @(negedge clk) rst_ni = 1'b1;
    for (int i = 0; i < NREG; i++) begin
      ref_q[i] = shadow_a[i]; ref_v[i] = shadow_v[i];
    end
    checks++;
    if (ref_q[7] !== 32'h0A0A_0007) begin
      errors++;
      $display("FAIL R8 model: actual %h expected %h", ref_q[7], 32'h0A0A_0007);
    end
    sweep("R8");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule